// File: doc/BRIEF.md
# Shared Pin Interrupt Controller for a Four-Pin Port

This block watches the four pins of an input port and turns activity on them into one shared interrupt. Each pin has its own enable and its own polarity: polarity 0 makes a pin respond to high-to-low changes or a low level, and polarity 1 makes it respond to low-to-high changes or a high level. One port-wide mode bit selects what sets the flag. With the bit at 0, only a transition into the asserted level sets it. With the bit at 1, a transition or a steady asserted level sets it.

The pins are sampled by two flip-flops on the bus clock before any detection takes place. Any qualifying event sets a single sticky flag. The interrupt request is that flag gated by an interrupt enable. Software clears the flag by writing a one to an acknowledge bit. In level mode the clear takes effect only once no enabled pin is still asserted.

A combinational wake output reports any enabled pin that sits at its asserted level, taken straight from the unsynchronised pins. It therefore works while the bus clock is stopped. Software reaches the block through a small write-strobe register port with a combinational read path.

Top module: `pinirq_ctrl`

## Requirements
- R1: After reset the flag, the interrupt request, the mode bit, the interrupt enable, the enable mask and the polarity mask all read 0.
- R2: A pin whose enable bit (address 1, bit n for pin n) is 0 never sets the flag, whatever it does.
- R3: With polarity 0 (address 2, bit n), a 1-to-0 change on an enabled pin sets the flag (address 0, bit 3). The flag reads 1 after the third rising clock edge that follows the change, and still reads 0 after the second.
- R4: With polarity 1, a 0-to-1 change on an enabled pin sets the flag after the same three-edge delay.
- R5: In edge mode (address 0, bit 0 = 0), a pin that is already asserted when it is enabled does not set the flag. It has to be seen deasserted first.
- R6: In level mode (address 0, bit 0 = 1), an enabled pin held at its asserted level sets the flag.
- R7: The irq output is 1 exactly when the flag is 1 and the interrupt enable (address 0, bit 1) is 1.
- R8: In edge mode, writing 1 to the acknowledge bit (address 0, bit 2) clears the flag at that clock edge.
- R9: In level mode, an acknowledge leaves the flag set while any enabled pin is still asserted. Once all enabled pins are deasserted, an acknowledge clears it.
- R10: When a set event and an acknowledge land on the same clock edge, the flag stays 1.
- R11: wake is the OR, over all enabled pins, of the raw pin being at its asserted level. It follows the pins without any clock edge.
- R12: The enable mask, the polarity mask, the mode bit and the interrupt enable read back as written. The acknowledge bit always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Raw port pin levels |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for reads and writes (0 control, 1 enable, 2 polarity) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for addr |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Combinational wake indication from the raw pins |

## Verification
A pin change driven between clock edges shows up in the flag only after the third following rising edge: two edges pass through the synchroniser and one loads the flag. The bench therefore reads the flag both after the second edge and after the third, to pin down the exact latency. Register writes and acknowledges act at the single edge where the strobe is high, so their results are read at the falling edge that follows. The wake output is combinational, so the bench checks it a nanosecond after the pin moves, while the clock is held in one phase. The same-edge collision between a set event and an acknowledge is lined up by counting two edges from the pin change and raising the acknowledge strobe for the third.

// File: rtl/pinirq_ctrl.sv
module pinirq_ctrl #(
  parameter int NPINS = 4,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  output logic             irq,
  output logic             wake
);

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_EN   = 2'd1;
  localparam logic [1:0] A_POL  = 2'd2;
  localparam int B_MODE = 0;
  localparam int B_IE   = 1;
  localparam int B_ACK  = 2;
  localparam int B_FLAG = 3;

  logic [NPINS-1:0] en_q, pol_q, s1_q, s2_q, hist_q;
  logic mode_q, ie_q, flag_q;

  wire [NPINS-1:0] act   = s2_q ^ ~pol_q;
  wire [NPINS-1:0] rise  = act & ~hist_q & en_q;
  wire             lvl   = |(act & en_q);
  wire             set_now = (|rise) | (mode_q & lvl);
  wire             ack_wr  = wr_en && (addr == A_CTRL) && wr_data[B_ACK];
  wire             unused_wdata = ^wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      hist_q <= '0;
    end else begin
      s1_q   <= pin_in;
      s2_q   <= s1_q;
      hist_q <= act;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '0;
      mode_q <= 1'b0;
      ie_q   <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL: begin
          mode_q <= wr_data[B_MODE];
          ie_q   <= wr_data[B_IE];
        end
        A_EN:    en_q  <= wr_data[NPINS-1:0];
        A_POL:   pol_q <= wr_data[NPINS-1:0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_now) flag_q <= 1'b1;
    else if (ack_wr)  flag_q <= 1'b0;

  always_comb begin
    rd_data = '0;
    case (addr)
      A_CTRL: begin
        rd_data[B_MODE] = mode_q;
        rd_data[B_IE]   = ie_q;
        rd_data[B_FLAG] = flag_q;
      end
      A_EN:    rd_data[NPINS-1:0] = en_q;
      A_POL:   rd_data[NPINS-1:0] = pol_q;
      default: ;
    endcase
  end

  assign irq  = flag_q & ie_q;
  assign wake = |(en_q & ~(pin_in ^ pol_q));

endmodule

// File: rtl/pinirq_chk.sv
module pinirq_chk #(
  parameter int NPINS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] act,
  input logic [NPINS-1:0] hist_q,
  input logic [NPINS-1:0] en_q,
  input logic             mode_q,
  input logic             ie_q,
  input logic             flag_q,
  input logic             ack_wr,
  input logic             irq
);

  // R3
  edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(act & ~hist_q & en_q) |=> flag_q);

  // R9
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && |(act & en_q)) |=> flag_q);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !ack_wr) |=> flag_q);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q |-> !irq);

  // R2
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(|en_q));

endmodule

bind pinirq_ctrl pinirq_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .act(act), .hist_q(hist_q), .en_q(en_q),
  .mode_q(mode_q), .ie_q(ie_q), .flag_q(flag_q), .ack_wr(ack_wr), .irq(irq)
);

// File: tb/sim_pinirq_ctrl.sv
module sim_pinirq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pin_in = 4'hF;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       irq, wake;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pinirq_ctrl u0 (.clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .wake(wake));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_data = 8'd0;
  endtask

  function automatic int flag_of(input logic [7:0] d);
    return int'(d[3]);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [3:0] idle);
    pin_in = idle; rst_n = 1'b0; wr_en = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    cyc(4);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset(4'hF);
    rd(2'd0, d); chk("R1 ctrl", d, 0);
    rd(2'd1, d); chk("R1 enable", d, 0);
    rd(2'd2, d); chk("R1 polarity", d, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    do_reset(4'hF);
    wr(2'd1, 8'h05); rd(2'd1, d); chk("R12 enable", d, 8'h05);
    wr(2'd2, 8'h0A); rd(2'd2, d); chk("R12 polarity", d, 8'h0A);
    wr(2'd0, 8'h07); rd(2'd0, d); chk("R12 ctrl ack reads 0", d & 8'h07, 8'h03);
  endtask

  task automatic t_fall();
    logic [7:0] d;
    do_reset(4'hF);
    wr(2'd1, 8'h01); wr(2'd0, 8'h02); cyc(3);
    pin_in[0] = 1'b0;
    cyc(2); rd(2'd0, d); chk("R3 flag after 2 edges", flag_of(d), 0);
    cyc(1); rd(2'd0, d); chk("R3 flag after 3 edges", flag_of(d), 1);
    chk("R7 irq with ie", irq, 1);
    wr(2'd0, 8'h00); chk("R7 irq without ie", irq, 0);
    wr(2'd0, 8'h04); rd(2'd0, d); chk("R8 ack clears", flag_of(d), 0);
  endtask

  task automatic t_rise();
    logic [7:0] d;
    do_reset(4'h0);
    wr(2'd2, 8'h04); wr(2'd1, 8'h04); cyc(3);
    pin_in[2] = 1'b1;
    cyc(2); rd(2'd0, d); chk("R4 flag after 2 edges", flag_of(d), 0);
    cyc(1); rd(2'd0, d); chk("R4 flag after 3 edges", flag_of(d), 1);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    do_reset(4'hF);
    wr(2'd1, 8'h01); cyc(3);
    pin_in[1] = 1'b0; cyc(3); pin_in[1] = 1'b1; cyc(3);
    rd(2'd0, d); chk("R2 disabled pin ignored", flag_of(d), 0);
    wr(2'd0, 8'h01);
    pin_in[3] = 1'b0; cyc(4);
    rd(2'd0, d); chk("R2 disabled pin level ignored", flag_of(d), 0);
  endtask

  task automatic t_preasserted();
    logic [7:0] d;
    do_reset(4'hE);
    cyc(3); wr(2'd1, 8'h01); cyc(5);
    rd(2'd0, d); chk("R5 no edge when already asserted", flag_of(d), 0);
    pin_in[0] = 1'b1; cyc(4); pin_in[0] = 1'b0; cyc(3);
    rd(2'd0, d); chk("R5 edge after deassert", flag_of(d), 1);
  endtask

  task automatic t_level();
    logic [7:0] d;
    do_reset(4'hE);
    wr(2'd0, 8'h01); wr(2'd1, 8'h01); cyc(2);
    rd(2'd0, d); chk("R6 level sets flag", flag_of(d), 1);
    wr(2'd0, 8'h05); rd(2'd0, d); chk("R9 ack blocked while asserted", flag_of(d), 1);
    pin_in[0] = 1'b1; cyc(4);
    wr(2'd0, 8'h05); rd(2'd0, d); chk("R9 ack after release", flag_of(d), 0);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    do_reset(4'hF);
    wr(2'd1, 8'h01); cyc(3);
    pin_in[0] = 1'b0; cyc(4);
    pin_in[0] = 1'b1; cyc(4);
    rd(2'd0, d); chk("R10 flag set before collision", flag_of(d), 1);
    pin_in[0] = 1'b0; cyc(2);
    wr(2'd0, 8'h04);
    rd(2'd0, d); chk("R10 set wins over ack", flag_of(d), 1);
  endtask

  task automatic t_wake();
    do_reset(4'h0);
    wr(2'd2, 8'h02); wr(2'd1, 8'h02);
    #1; chk("R11 wake idle", wake, 0);
    pin_in[1] = 1'b1; #1; chk("R11 wake follows raw pin", wake, 1);
    pin_in[1] = 1'b0; pin_in[0] = 1'b0; #1; chk("R11 disabled pin no wake", wake, 0);
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_fall();
    t_rise();
    t_disabled();
    t_preasserted();
    t_level();
    t_collide();
    t_wake();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule